// File: doc/BRIEF.md
# NAND Command Front End with Column Pointer

This block is a device-side model of an 8-bit multiplexed NAND flash bus, written to be synthesizable and small, so that a flash controller can be exercised against it in simulation. The controller drives command, address and data bytes over one shared byte lane. Each byte is qualified by the command-latch and address-latch strobes and taken on the rising edge of the active-low write strobe. Read data, identification bytes and the status byte are returned one per falling edge of the active-low read strobe. All bus pins are sampled on the block clock, and strobe edges are found by comparing each pin with its value one clock earlier.

Behind the bus sit a 528-byte page buffer and a tiny array of a few pages grouped into erase blocks. A read, program, erase or reset holds the ready output low for a fixed, parameterised number of clocks. Programming can only clear bits, and erase sets a whole block to FFh. A column pointer chooses where the first address byte lands: in the first half, in the second half, or in the 16-byte spare tail of the page. The second-half choice applies to one operation only.

Top module: `nand_cmd_front`

## Requirements
- R1: After rst_n or after command FFh, ready is high once any busy time has run out, the pointer is the first half, the block is in page-read mode, and a status read returns C0h while wp_n is high.
- R2: The first address byte gives the start column as follows: after 00h it is the byte itself (0..255); after 01h it is 256 plus the byte; after 50h it is 512 plus the byte's low four bits, and the upper four bits are ignored.
- R3: The 00h and 50h pointer choices stay in force over later operations. The 01h choice falls back to the first half after the next read start, program, erase or reset.
- R4: A read starts on its third address byte. ready then stays low for exactly BUSY_CYCLES clocks. After that, each read-strobe fall returns the byte at the column counter and advances the counter by one, but the counter never goes past column 527.
- R5: Address bytes beyond the count an operation needs are ignored: three for read and program, two row bytes for erase (80h/60h flows), one for ID.
- R6: The sequence 80h, three address bytes, serial data and 10h stores the bitwise AND of the old byte and the loaded byte, and bytes that were not loaded keep their value. A 10h with no data byte since 80h starts nothing, and ready stays high.
- R7: The sequence 60h, two row bytes and D0h sets every byte of every page in the addressed block to FFh, and leaves the other blocks unchanged. A block is PAGES_PER_BLK consecutive pages.
- R8: While ready is low, only 70h and FFh are accepted. Every other command, address byte and data byte is ignored.
- R9: After 70h, each read-strobe fall returns status: bit 7 is the wp_n level, bit 6 is ready, bit 0 is the fail flag of the last program or erase, and the other bits are 0. Status mode lasts until the next accepted command. A 00h given without address bytes resumes page data at the next column.
- R10: When wp_n is low at 10h or D0h, the array is left unchanged, ready still drops, and the fail flag is set.
- R11: After 90h and one address byte, read-strobe falls return ID_FIRST and ID_SECOND in turn (defaults A5h, 3Ch).
- R12: A command code outside 00h, 01h, 50h, 80h, 10h, 60h, D0h, 70h, 90h and FFh is ignored and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Command-latch strobe |
| ale | input | 1 | Address-latch strobe |
| we_n | input | 1 | Active-low write strobe; its rising edge takes the byte |
| re_n | input | 1 | Active-low read strobe; its falling edge returns a byte |
| wp_n | input | 1 | Active-low write protect |
| io_in | input | 8 | Byte lane from the controller |
| io_out | output | 8 | Byte returned on the last read-strobe fall |
| io_oe | output | 1 | High while the read strobe is low (lane drive enable) |
| ready | output | 1 | High when no operation is in progress |

## Verification
A status read and the busy countdown can fall in the same cycle. So can a command arrival and that same countdown. The bench issues 70h and then 90h within the busy window that follows a 10h. The status byte taken there must show bit 6 clear. The stray 90h must leave the block in status mode, so that once ready returns a further read-strobe fall gives C0h and not an ID byte.

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int NUM_PAGES     = 4,
  parameter int PAGES_PER_BLK = 2,
  parameter int HALF_BYTES    = 256,
  parameter int SPARE_BYTES   = 16,
  parameter int BUSY_CYCLES   = 12,
  parameter logic [7:0] ID_FIRST  = 8'hA5,
  parameter logic [7:0] ID_SECOND = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       ready
);
  localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES;
  localparam int LAST_COL   = PAGE_BYTES - 1;
  localparam int CW  = $clog2(PAGE_BYTES + 1);
  localparam int PW  = $clog2(NUM_PAGES);
  localparam int BSH = $clog2(PAGES_PER_BLK);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {MD_IDLE, MD_READ, MD_STATUS, MD_ID, MD_PROG, MD_ERASE} mode_t;
  typedef enum logic [1:0] {PT_A, PT_B, PT_C} ptr_t;

  logic [NUM_PAGES-1:0][PAGE_BYTES*8-1:0] mem;
  logic [PAGE_BYTES*8-1:0] pgreg;

  mode_t          mode;
  ptr_t           ptr;
  logic [1:0]     acnt, aneed;
  logic [CW-1:0]  col, start_col;
  logic [PW-1:0]  page;
  logic [BCW-1:0] busy_cnt;
  logic           fail, data_seen, data_ok, id_sel, we_q, re_q;
  logic [7:0]     dout;

  wire we_rise = we_n & ~we_q;
  wire re_fall = ~re_n & re_q;
  wire cmd_stb = we_rise & cle & ~ale;
  wire adr_stb = we_rise & ale & ~cle;
  wire dat_stb = we_rise & ~cle & ~ale;
  wire [7:0] status_byte = {wp_n, ready, 5'b0, fail};

  wire prog_go  = cmd_stb && ready && io_in == 8'h10 && mode == MD_PROG && data_seen;
  wire erase_go = cmd_stb && ready && io_in == 8'hD0 && mode == MD_ERASE && acnt == 2'd2;
  wire read_go  = adr_stb && ready && mode == MD_READ && acnt == 2'd2;
  wire load_ok  = dat_stb && ready && mode == MD_PROG && acnt == 2'd3 && col <= CW'(LAST_COL);

  assign ready  = busy_cnt == '0;
  assign io_out = dout;
  assign io_oe  = ~re_q;

  always_comb begin
    case (ptr)
      PT_B:    start_col = CW'(HALF_BYTES) + CW'(io_in);
      PT_C:    start_col = CW'(2 * HALF_BYTES) + CW'(io_in & 8'(SPARE_BYTES - 1));
      default: start_col = CW'(io_in);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_READ; ptr <= PT_A; acnt <= '0; aneed <= 2'd3;
      col <= '0; page <= '0; busy_cnt <= '0; fail <= 1'b0;
      data_seen <= 1'b0; data_ok <= 1'b0; id_sel <= 1'b0;
      we_q <= 1'b1; re_q <= 1'b1; dout <= '0;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (ptr == PT_B && (prog_go || erase_go || read_go)) ptr <= PT_A;

      if (cmd_stb) begin
        if (io_in == 8'hFF) begin
          mode <= MD_READ; ptr <= PT_A; acnt <= '0; aneed <= 2'd3;
          fail <= 1'b0; data_seen <= 1'b0; data_ok <= 1'b0;
          busy_cnt <= BCW'(BUSY_CYCLES);
        end else if (io_in == 8'h70) begin
          mode <= MD_STATUS;
        end else if (ready) begin
          case (io_in)
            8'h00: begin ptr <= PT_A; mode <= MD_READ; acnt <= '0; aneed <= 2'd3; end
            8'h01: begin ptr <= PT_B; mode <= MD_READ; acnt <= '0; aneed <= 2'd3; end
            8'h50: begin ptr <= PT_C; mode <= MD_READ; acnt <= '0; aneed <= 2'd3; end
            8'h90: begin mode <= MD_ID; acnt <= '0; aneed <= 2'd1; id_sel <= 1'b0; end
            8'h80: begin
              mode <= MD_PROG; acnt <= '0; aneed <= 2'd3;
              data_seen <= 1'b0; data_ok <= 1'b0;
            end
            8'h60: begin mode <= MD_ERASE; acnt <= '0; aneed <= 2'd2; data_ok <= 1'b0; end
            8'h10: if (prog_go) begin
              mode <= MD_IDLE; data_seen <= 1'b0; fail <= ~wp_n;
              busy_cnt <= BCW'(BUSY_CYCLES);
            end
            8'hD0: if (erase_go) begin
              mode <= MD_IDLE; fail <= ~wp_n;
              busy_cnt <= BCW'(BUSY_CYCLES);
            end
            default: ;
          endcase
        end
      end

      if (adr_stb && ready && acnt < aneed) begin
        acnt <= acnt + 1'b1;
        case (mode)
          MD_READ, MD_PROG: begin
            if (acnt == 2'd0) col <= start_col;
            else if (acnt == 2'd1) page <= io_in[PW-1:0];
          end
          MD_ERASE: if (acnt == 2'd0) page <= io_in[PW-1:0];
          default: ;
        endcase
        if (read_go) begin
          busy_cnt <= BCW'(BUSY_CYCLES);
          data_ok  <= 1'b1;
        end
      end

      if (load_ok) begin
        col <= col + 1'b1;
        data_seen <= 1'b1;
      end

      if (re_fall) begin
        case (mode)
          MD_STATUS: dout <= status_byte;
          MD_ID: if (ready) begin
            dout <= id_sel ? ID_SECOND : ID_FIRST;
            id_sel <= ~id_sel;
          end
          MD_READ: if (ready && data_ok) begin
            dout <= mem[page][{col, 3'b000} +: 8];
            if (col < CW'(LAST_COL)) col <= col + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem   <= '1;
      pgreg <= '1;
    end else begin
      if (cmd_stb && ready && io_in == 8'h80) pgreg <= '1;
      if (load_ok) pgreg[{col, 3'b000} +: 8] <= io_in;
      if (prog_go && wp_n) mem[page] <= mem[page] & pgreg;
      if (erase_go && wp_n) begin
        for (int p = 0; p < NUM_PAGES; p++)
          if ((p >> BSH) == (int'(page) >> BSH)) mem[p] <= '1;
      end
    end
  end

  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(we_rise));

  assert_col_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (re_fall && mode == MD_READ && ready && data_ok && col == CW'(LAST_COL)) |=> col == CW'(LAST_COL));

  assert_spare_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_stb && ready && acnt == 2'd0 && ptr == PT_C && (mode == MD_READ || mode == MD_PROG))
      |=> (col >= CW'(2 * HALF_BYTES) && col <= CW'(LAST_COL)));

  assert_half_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PT_B && (prog_go || erase_go || read_go)) |=> ptr == PT_A);

  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && we_rise && !cle) |=> ($stable(col) && $stable(acnt) && $stable(page)));

  assert_no_data_no_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && ready && io_in == 8'h10 && !data_seen) |=> ready);

  assert_protect_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_go || erase_go) && !wp_n) |=> (fail && !ready));
endmodule

// File: tb/nand_cmd_front_bench.sv
module nand_cmd_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [7:0] io_out;
  logic io_oe, ready;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_cmd_front #(.BUSY_CYCLES(BUSY)) u_nand_cmd_front (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .ready(ready));

  // table: command, page, first address byte, expected start column
  localparam logic [33:0] VEC [7] = '{
    {8'h00, 8'd1, 8'h10, 10'd16},
    {8'h01, 8'd1, 8'h10, 10'd272},
    {8'h50, 8'd1, 8'h13, 10'd515},
    {8'h50, 8'd1, 8'hF3, 10'd515},
    {8'h00, 8'd1, 8'hFF, 10'd255},
    {8'h01, 8'd1, 8'hFF, 10'd511},
    {8'h50, 8'd1, 8'h0F, 10'd527}
  };

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((i * 7 + p * 29 + 3) % 256);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic a, input logic [7:0] d);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  pulse(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  pulse(1'b0, 1'b1, d); endtask
  task automatic din(input logic [7:0] d);  pulse(1'b0, 1'b0, d); endtask

  task automatic rd(output logic [7:0] v);
    re_n = 1'b0;
    @(negedge clk);
    v = io_out;
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic start_read(input logic [7:0] c, input logic [7:0] a, input logic [7:0] pg);
    cmd(c); adr(a); adr(pg); adr(8'h00);
    wait_ready();
  endtask

  task automatic prog1(input logic [7:0] a, input logic [7:0] pg, input logic [7:0] d);
    cmd(8'h80); adr(a); adr(pg); adr(8'h00); din(d); cmd(8'h10);
    wait_ready();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {7'b0, ready}, 8'h01);
    chk("R1 lane not driven", {7'b0, io_oe}, 8'h00);
    cmd(8'h70); rd(v); chk("R1 status after reset", v, 8'hC0);

    cmd(8'h00); cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 528; i++) din(pat(1, i));
    cmd(8'h10);
    chk("R6 program goes busy", {7'b0, ready}, 8'h00);
    wait_ready();
    prog1(8'h00, 8'h00, 8'h12);

    for (int k = 0; k < 7; k++) begin
      cmd(VEC[k][33:26]); adr(VEC[k][17:10]); adr(VEC[k][25:18]); adr(8'h00);
      n = 0;
      while (!ready) begin n++; @(negedge clk); end
      chk("R4 busy length", 8'(n), 8'(BUSY));
      c = int'(VEC[k][9:0]);
      rd(v); chk("R2 start column byte", v, pat(int'(VEC[k][25:18]), c));
      rd(v); chk("R4 next column byte", v, pat(int'(VEC[k][25:18]), (c == 527) ? 527 : c + 1));
    end
    rd(v); chk("R4 saturated at last column", v, pat(1, 527));

    cmd(8'h80); adr(8'h02); adr(8'h02); adr(8'h00); din(8'h3C); cmd(8'h10);
    cmd(8'h70); rd(v); chk("R8 status while busy", v, 8'h80);
    cmd(8'h90);
    wait_ready();
    rd(v); chk("R8 command during busy ignored", v, 8'hC0);
    prog1(8'h04, 8'h02, 8'h81);
    start_read(8'h50, 8'h02, 8'h02); rd(v); chk("R3 spare pointer first program", v, 8'h3C);
    start_read(8'h50, 8'h04, 8'h02); rd(v); chk("R3 spare pointer persists", v, 8'h81);

    cmd(8'h01); prog1(8'h00, 8'h02, 8'h0F);
    prog1(8'h00, 8'h02, 8'hF0);
    start_read(8'h00, 8'h00, 8'h02); rd(v); chk("R3 half pointer reverted", v, 8'hF0);
    start_read(8'h01, 8'h00, 8'h02); rd(v); chk("R3 second half programmed once", v, 8'h0F);

    cmd(8'h01); cmd(8'hFF);
    chk("R1 reset goes busy", {7'b0, ready}, 8'h00);
    wait_ready();
    cmd(8'h70); rd(v); chk("R1 status after reset command", v, 8'hC0);
    prog1(8'h01, 8'h03, 8'h77);
    start_read(8'h00, 8'h01, 8'h03); rd(v); chk("R3 reset clears half pointer", v, 8'h77);
    start_read(8'h01, 8'h01, 8'h03); rd(v); chk("R3 second half untouched", v, 8'hFF);

    prog1(8'h03, 8'h01, 8'h0F);
    start_read(8'h00, 8'h03, 8'h01); rd(v); chk("R6 program ANDs", v, pat(1, 3) & 8'h0F);

    cmd(8'h80); adr(8'h00); adr(8'h03); adr(8'h00); cmd(8'h10);
    chk("R6 10h without data stays ready", {7'b0, ready}, 8'h01);
    start_read(8'h00, 8'h00, 8'h03); rd(v); chk("R6 no program without data", v, 8'hFF);

    start_read(8'h00, 8'd20, 8'h01);
    rd(v); chk("R4 sequential byte 20", v, pat(1, 20));
    rd(v); chk("R4 sequential byte 21", v, pat(1, 21));
    cmd(8'h70); rd(v); chk("R9 status mode", v, 8'hC0);
    rd(v); chk("R9 status mode held", v, 8'hC0);
    cmd(8'h00); rd(v); chk("R9 resume after 00h", v, pat(1, 22));
    cmd(8'h3C); rd(v); chk("R12 undefined code in read", v, pat(1, 23));
    cmd(8'h70); cmd(8'hB5); rd(v); chk("R12 undefined code in status", v, 8'hC0);

    cmd(8'h90); adr(8'h00);
    rd(v); chk("R11 first id", v, 8'hA5);
    rd(v); chk("R11 second id", v, 8'h3C);
    rd(v); chk("R11 id wraps", v, 8'hA5);

    wp_n = 1'b0;
    prog1(8'h05, 8'h01, 8'h00);
    cmd(8'h70); rd(v); chk("R10 protected status", v, 8'h41);
    wp_n = 1'b1;
    start_read(8'h00, 8'h05, 8'h01); rd(v); chk("R10 array unchanged", v, pat(1, 5));

    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h02); cmd(8'hD0);
    chk("R7 erase goes busy", {7'b0, ready}, 8'h00);
    wait_ready();
    start_read(8'h00, 8'h00, 8'h00); rd(v); chk("R7 page 0 erased", v, 8'hFF);
    start_read(8'h00, 8'h03, 8'h01); rd(v); chk("R7 page 1 erased", v, 8'hFF);
    start_read(8'h00, 8'h00, 8'h02); rd(v); chk("R5 extra row byte ignored", v, 8'hF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule